// File: doc/BRIEF.md
# Serial Frame Transmitter with Preamble and Break

This block turns parallel words into asynchronous NRZ frames on a single line that rests high. Software-facing logic writes a word into a holding register. The sequencer moves that word into a shift register at a frame boundary and clocks it out one bit per baud tick. A frame-length select picks between short frames and long frames. A short frame is a start bit, 8 data bits and a stop bit, for 10 bits in all. A long frame is a start bit, 9 data bits and a stop bit, for 11 bits in all.

The block can also put two special conditions on the line. When the transmit enable goes from 0 to 1, the block first sends one frame-length of all-ones as a preamble. While the break request is held, the block sends frame-length groups of zeros back to back. When the break is released, the block drives one mark bit before any later frame. Two flags report progress: the holding register is empty, and the transmitter is complete.

The sequencer is a five-state machine with these states:
- `S_IDLE`: the line is high and no frame is in progress.
- `S_PRE`: the block is sending the preamble.
- `S_DATA`: the block is sending a data frame.
- `S_BRK`: the block is sending a break group.
- `S_MARK`: the block is sending the single high bit after a break.

The state can change only on a baud tick, and only at a frame boundary. A boundary is any tick while in `S_IDLE`, the last tick of a `S_PRE`, `S_DATA` or `S_BRK` frame, or the single tick of `S_MARK`. At a boundary the next state is chosen in this order of priority:
1. Enable low leads to `S_IDLE`.
2. A pending preamble leads to `S_PRE`.
3. Leaving `S_BRK` with the break released leads to `S_MARK`.
4. A break request leads to `S_BRK`.
5. A full holding register leads to `S_DATA`.
6. Otherwise the next state is `S_IDLE`.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is 1, the empty flag `tdre` is 1, the complete flag `tc` is 1, and no frame starts until enable is set.
- R2: The line changes only in the clock cycle after a cycle with `baud_tick` high, so each serial bit lasts exactly one tick period.
- R3: A 0-to-1 change of `tx_en` causes one preamble of logic 1s before any other frame. The preamble is 10 ticks long when `long_mode`=0 and 11 ticks long when `long_mode`=1.
- R4: A data frame is a 0 start bit, then `wr_data[7:0]` LSB first (`long_mode`=0) or `wr_data[8:0]` LSB first (`long_mode`=1), then a 1 stop bit.
- R5: While `brk_req`=1 and `tx_en`=1, the line carries back-to-back groups of 0s, each 10 or 11 ticks long by `long_mode`, with no gap between groups. When `tx_en`=0, `brk_req` has no effect and the line stays 1.
- R6: After `brk_req` is cleared, the current break group finishes. The line is then 1 for exactly one tick before any following frame starts.
- R7: `brk_req` is sampled only at frame boundaries. A data frame already in progress completes unchanged before the zeros begin.
- R8: With `tx_en`=0 no frame starts and the line stays 1. Clearing `tx_en` during a frame lets that frame complete, after which the line stays 1 even if data is waiting.
- R9: `tdre` falls on a write and rises in the cycle after the tick on which the word is moved into the shift register.
- R10: `tc` is 1 only when no frame is in progress and the holding register is empty.
- R11: If a new word is written before the last tick of the current data frame, the next frame follows with no idle bit in between. At a boundary the preamble has priority over the break, and the break has priority over pending data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| brk_req | input | 1 | Send-break request |
| long_mode | input | 1 | 1 selects 11-bit frames, 0 selects 10-bit frames |
| baud_tick | input | 1 | Single-cycle pulse, one per bit time |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | DATA_W+1 | Word to send; the top bit is used only in long mode |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmitter complete (idle with nothing pending) |
| txd | output | 1 | Serial line, high when idle |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse. They also assume that the control inputs and `long_mode` are changed only between ticks, never in the cycle of a tick, so the sampled values are well defined. The bench drives every input on a falling clock edge and holds `baud_tick` high for exactly one cycle. It leaves quiet cycles after each tick, which lets it check that the line holds still between ticks. Writes are placed between ticks, and never more than one per frame, so the holding register is never overwritten before it has been loaded.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PRE  = 3'd1,
        S_DATA = 3'd2,
        S_BRK  = 3'd3,
        S_MARK = 3'd4
    } tx_state_e;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W:0]   wr_data,
    input  logic              load,
    output logic [DATA_W:0]   hold_data,
    output logic              hold_full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_data <= wr_data;
                hold_full <= 1'b1;
            end else if (load) begin
                hold_full <= 1'b0;
            end
        end
    end

    // a load with no simultaneous write leaves the register empty
    assert_empty_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> !hold_full);
    assert_full_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hold_full);
endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      tx_en,
    input  logic      brk_req,
    input  logic      long_mode,
    input  logic      hold_full,
    output tx_state_e state,
    output tx_state_e choice,
    output logic      start,
    output logic      load,
    output logic      long_nx
);
    localparam int SHORT_LEN = DATA_W + 2;
    localparam int LONG_LEN  = DATA_W + 3;
    localparam int CNT_W     = $clog2(LONG_LEN);

    logic [CNT_W-1:0] cnt;
    logic             flen_long;
    logic             en_q;
    logic             pre_pend;
    logic             pre_want;
    logic [CNT_W-1:0] last_idx;
    logic             at_end;
    logic             boundary;

    // frame length of the current frame
    always_comb begin
        unique case (state)
            S_MARK:  last_idx = '0;
            default: last_idx = flen_long ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1);
        endcase
        at_end   = (state == S_IDLE) || (cnt == last_idx);
        boundary = tick && at_end;
        pre_want = tx_en && (pre_pend || !en_q);
    end

    // next frame kind chosen at a boundary, by priority
    always_comb begin
        if (!tx_en)
            choice = S_IDLE;
        else if (pre_want)
            choice = S_PRE;
        else if (state == S_BRK && !brk_req)
            choice = S_MARK;
        else if (brk_req)
            choice = S_BRK;
        else if (hold_full)
            choice = S_DATA;
        else
            choice = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else if (boundary)
            state <= choice;
    end

    // counter, length latch, enable edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            flen_long <= 1'b0;
            en_q      <= 1'b0;
            pre_pend  <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (boundary) begin
                cnt       <= '0;
                flen_long <= long_mode;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
            if (!tx_en)
                pre_pend <= 1'b0;
            else if (boundary && choice == S_PRE)
                pre_pend <= 1'b0;
            else if (!en_q)
                pre_pend <= 1'b1;
        end
    end

    // outputs toward shifter and holding register
    always_comb begin
        start   = boundary;
        load    = boundary && (choice == S_DATA);
        long_nx = long_mode;
    end

    assert_state_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));
    assert_idle_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !tx_en) |=> state == S_IDLE);
    assert_frame_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && tick && !at_end) |=> state == S_DATA);
    assert_mark_after_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRK && boundary && tx_en && !brk_req && !pre_want) |=> state == S_MARK);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            start,
    input  tx_state_e       kind,
    input  logic            long_sel,
    input  logic [DATA_W:0] data,
    output logic            txd
);
    localparam int FRAME_W = DATA_W + 3;

    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] pattern;

    always_comb begin
        unique case (kind)
            S_DATA:  pattern = long_sel ? {1'b1, data, 1'b0}
                                        : {2'b11, data[DATA_W-1:0], 1'b0};
            S_BRK:   pattern = '0;
            default: pattern = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '1;
        else if (tick) begin
            if (start)
                shreg <= pattern;
            else
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
        end
    end

    assign txd = shreg[0];

    assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            brk_req,
    input  logic            long_mode,
    input  logic            baud_tick,
    input  logic            wr_en,
    input  logic [DATA_W:0] wr_data,
    output logic            tdre,
    output logic            tc,
    output logic            txd
);
    tx_state_e       state;
    tx_state_e       choice;
    logic            start;
    logic            load;
    logic            long_nx;
    logic [DATA_W:0] hold_data;
    logic            hold_full;

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .load(load), .hold_data(hold_data), .hold_full(hold_full)
    );

    sertx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .tx_en(tx_en),
        .brk_req(brk_req), .long_mode(long_mode), .hold_full(hold_full),
        .state(state), .choice(choice), .start(start), .load(load),
        .long_nx(long_nx)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(start),
        .kind(choice), .long_sel(long_nx), .data(hold_data), .txd(txd)
    );

    always_comb begin
        tdre = !hold_full;
        tc   = (state == S_IDLE) && !hold_full;
    end

    assert_break_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRK) |-> !txd);
    assert_preamble_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE || state == S_MARK || state == S_IDLE) |-> txd);
    assert_tc_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (txd && tdre));
endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        brk_req = 1'b0;
    logic        long_mode = 1'b0;
    logic        baud_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [DW:0] wr_data = '0;
    logic        tdre, tc, txd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sertx_top #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
        .long_mode(long_mode), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .tdre(tdre), .tc(tc), .txd(txd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one tick; returns the line value that follows it; checks line holds between ticks (R2)
    task automatic tk(output bit b);
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        b = txd;
        @(negedge clk);
        chk(txd == b, "R2", txd, b);
    endtask

    task automatic expect_bits(input int n, input bit v, input string req);
        bit b;
        for (int i = 0; i < n; i++) begin
            tk(b);
            chk(b == v, req, b, v);
        end
    endtask

    task automatic wr(input int v);
        @(negedge clk) begin wr_en = 1'b1; wr_data = v[DW:0]; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    function automatic bit fbit(input int v, input bit lg, input int i);
        int n = lg ? DW + 1 : DW;
        if (i == 0) return 1'b0;
        if (i <= n) return v[i-1];
        return 1'b1;
    endfunction

    // sends remaining bits 1..len-1 of a frame whose start bit was already observed
    task automatic frame_rest(input int v, input bit lg, input int from, input int upto);
        bit b;
        for (int i = from; i < upto; i++) begin
            tk(b);
            chk(b == fbit(v, lg, i), "R4", b, fbit(v, lg, i));
        end
    endtask

    task automatic sweep(input bit lg);
        int cnt = lg ? 512 : 256;
        int len = lg ? DW + 3 : DW + 2;
        bit b;
        long_mode = lg;
        wr(0);
        chk(tdre == 1'b0, "R9", tdre, 0);
        @(negedge clk) tx_en = 1'b1;
        expect_bits(len, 1'b1, "R3");
        for (int v = 0; v < cnt; v++) begin
            tk(b);
            chk(b == 1'b0, "R4", b, 0);
            chk(tdre == 1'b1, "R9", tdre, 1);
            chk(tc == 1'b0, "R10", tc, 0);
            if (v < cnt - 1) wr(v + 1);   // refill in time: back-to-back (R11)
            frame_rest(v, lg, 1, len);
        end
        tk(b);
        chk(b == 1'b1, "R11", b, 1);
        chk(tc == 1'b1, "R10", tc, 1);
        @(negedge clk) tx_en = 1'b0;
    endtask

    initial begin
        bit b;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1", txd, 1);
        chk(tdre == 1'b1, "R1", tdre, 1);
        chk(tc == 1'b1, "R1", tc, 1);
        @(negedge clk) rst_n = 1'b1;
        expect_bits(3, 1'b1, "R1");

        sweep(1'b0);
        sweep(1'b1);

        // R8 and R5: disabled block ignores data and break
        long_mode = 1'b0;
        wr(9'h055);
        @(negedge clk) brk_req = 1'b1;
        expect_bits(12, 1'b1, "R8");
        chk(tdre == 1'b0, "R8", tdre, 0);
        @(negedge clk) begin brk_req = 1'b0; end

        // R11 priority: preamble, then break, then data
        @(negedge clk) begin tx_en = 1'b1; brk_req = 1'b1; end
        expect_bits(10, 1'b1, "R3");
        expect_bits(20, 1'b0, "R5");
        @(negedge clk) brk_req = 1'b0;
        tk(b);
        chk(b == 1'b1, "R6", b, 1);
        tk(b);
        chk(b == 1'b0, "R11", b, 0);
        frame_rest(9'h055, 1'b0, 1, 10);

        // R7 break requested mid-frame
        wr(9'h0A3);
        tk(b);
        chk(b == 1'b0, "R7", b, 0);
        frame_rest(9'h0A3, 1'b0, 1, 4);
        @(negedge clk) brk_req = 1'b1;
        frame_rest(9'h0A3, 1'b0, 4, 10);
        expect_bits(10, 1'b0, "R7");
        @(negedge clk) brk_req = 1'b0;
        tk(b);
        chk(b == 1'b1, "R6", b, 1);
        tk(b);
        chk(b == 1'b1, "R6", b, 1);
        chk(tc == 1'b1, "R10", tc, 1);

        // R8 disable mid-frame
        wr(9'h03C);
        tk(b);
        chk(b == 1'b0, "R8", b, 0);
        wr(9'h199);
        frame_rest(9'h03C, 1'b0, 1, 5);
        @(negedge clk) tx_en = 1'b0;
        frame_rest(9'h03C, 1'b0, 5, 10);
        expect_bits(12, 1'b1, "R8");
        chk(tdre == 1'b0, "R8", tdre, 0);
        chk(tc == 1'b0, "R10", tc, 0);

        // R3 long preamble on re-enable, then waiting long word
        long_mode = 1'b1;
        @(negedge clk) tx_en = 1'b1;
        expect_bits(11, 1'b1, "R3");
        tk(b);
        chk(b == 1'b0, "R4", b, 0);
        frame_rest(9'h199, 1'b1, 1, 11);
        tk(b);
        chk(tc == 1'b1, "R10", tc, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule